// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a slower memory that moves whole lines. Every byte address is cut into three fields. The low bits select a byte within the line. The next bits pick the one line the address may occupy. The remaining high bits form the tag, which is kept beside the line together with a valid flag and a dirty flag.

A request whose line is valid and whose tag matches completes one cycle after it is presented, with no memory traffic. A store hit changes only the cached copy and marks the line dirty. Any other request is a miss. On a miss the controller stalls the processor. If the line being replaced is dirty, the controller first writes it to memory. It then fetches the whole new line and finally replays the pending load or store against it. Stores therefore allocate, and the store bytes are merged into the fetched line.

The processor pulses `cpu_req` for one cycle while `cpu_stall` is low, then waits for the one-cycle `cpu_done` pulse. Read data is valid on `cpu_rdata` when `cpu_done` is high.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, and `cpu_done`, `cpu_stall` and `mem_req_valid` are low. The first access to any line is a miss.
- R2: The byte offset is `addr[OFF_W-1:0]`, the line index is `addr[OFF_W+IDX_W-1:OFF_W]`, and the tag is the bits above them. With 64 lines of 16 bytes, address 1200 falls in block 75 and shares line 11 with address 3248.
- R3: A request that finds its line valid with an equal tag raises `cpu_done` in the next cycle and issues no memory request.
- R4: A miss raises `cpu_stall` from the cycle after the request until the access is finished. It issues exactly one line read at the line-aligned address of the request. `cpu_done` is never high while `cpu_stall` is high.
- R5: A store hit issues no memory write.
- R6: When the line being replaced is dirty, its contents are written to memory at its own line-aligned address before the line read for the new address is issued.
- R7: When the line being replaced is clean or invalid, no memory write occurs.
- R8: A store miss fetches the whole line first. It then replaces only the bytes whose bit in `cpu_be` is 1 (bit b covers data bits 8b+7:8b), and the other words of the line keep the fetched values.
- R9: A load returns the latest value stored to its word address, whether that value is in the cache or came back from memory.
- R10: Configured as 8 lines of one 32-bit word, the word-address sequence 22, 26, 22, 26, 16, 3, 16, 18 gives miss, miss, hit, hit, miss, miss, hit, miss.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request (`mem_req_valid`, `mem_req_we`, `mem_req_addr`) holds unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request pulse, presented only while `cpu_stall` is low |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W (32) | Byte address |
| cpu_wdata | input | WORD_W (32) | Store data |
| cpu_be | input | WORD_W/8 (4) | Byte enables for stores |
| cpu_rdata | output | WORD_W (32) | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | Access finished |
| cpu_stall | output | 1 | Controller busy with a miss |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for a line write, 0 for a line read |
| mem_req_addr | output | ADDR_W (32) | Line-aligned byte address |
| mem_wdata | output | WORD_W*LINE_WORDS (128) | Line being written back |
| mem_rvalid | input | 1 | Fetched line is present on `mem_rdata` |
| mem_rdata | input | WORD_W*LINE_WORDS (128) | Fetched line |

## Verification
The default geometry is swept across all 64 lines with several patterns. A cold pass separates misses from hits. A repeated pass proves that tags were stored. A pass of stores with rotating byte enables separates cache-only updates from memory writes. A conflicting pass, offset by the cache size, tells dirty replacement from clean replacement. A replay of the original region then confirms that written-back data returns intact. Store misses with partial byte enables separate merged bytes from fetched bytes. Addresses 1200, 3248 and 1184 pin down which line an address maps to, and a second instance with eight one-word lines replays the short conflict sequence.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WRITEBACK = 2'd1,
    ST_REFILL    = 2'd2,
    ST_RESPOND   = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
`timescale 1ns/1ps
module cache_tag_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // flags need reset, tags do not: keeps the tag array RAM-friendly
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/cache_line_store.sv
`timescale 1ns/1ps
module cache_line_store #(
  parameter int LINES  = 64,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_line;
  end

  assign rd_line = mem[rd_idx];
endmodule

// File: rtl/cache_fsm.sv
`timescale 1ns/1ps
module cache_fsm
  import cache_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cpu_req,
  input  logic         hit,
  input  logic         victim_dirty,
  input  logic         mem_req_ready,
  input  logic         mem_rvalid,
  output cache_state_e state,
  output logic         access_en,
  output logic         fill_en,
  output logic         lat_req,
  output logic         ld_wb,
  output logic         ld_fill,
  output logic         mem_req_valid,
  output logic         mem_req_we,
  output logic         cpu_done
);
  logic wb_accept;

  always_comb begin
    access_en = ((state == ST_IDLE) && cpu_req && hit) || (state == ST_RESPOND);
    lat_req   = (state == ST_IDLE) && cpu_req && !hit;
    wb_accept = (state == ST_WRITEBACK) && mem_req_valid && mem_req_ready;
    ld_wb     = lat_req && victim_dirty;
    ld_fill   = (lat_req && !victim_dirty) || wb_accept;
    fill_en   = (state == ST_REFILL) && mem_rvalid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      cpu_done      <= 1'b0;
    end else begin
      cpu_done <= access_en;
      unique case (state)
        ST_IDLE: begin
          if (lat_req) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= victim_dirty;
            state         <= victim_dirty ? ST_WRITEBACK : ST_REFILL;
          end
        end
        ST_WRITEBACK: begin
          if (wb_accept) begin
            mem_req_we <= 1'b0;
            state      <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
          if (mem_rvalid) state <= ST_RESPOND;
        end
        ST_RESPOND: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_wb_cache.sv
`timescale 1ns/1ps
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 64,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int LINE_W     = WORD_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [WORD_W-1:0]     cpu_wdata,
  input  logic [WORD_BYTES-1:0] cpu_be,
  output logic [WORD_W-1:0]     cpu_rdata,
  output logic                  cpu_done,
  output logic                  cpu_stall,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_we,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [LINE_W-1:0]     mem_wdata,
  input  logic                  mem_rvalid,
  input  logic [LINE_W-1:0]     mem_rdata
);
  localparam int BOFF_W     = $clog2(WORD_BYTES);
  localparam int LINE_BYTES = WORD_BYTES * LINE_WORDS;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(LINES);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int WSEL_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

  cache_state_e state;

  logic [ADDR_W-1:0]     req_addr_q;
  logic                  req_we_q;
  logic [WORD_W-1:0]     req_wdata_q;
  logic [WORD_BYTES-1:0] req_be_q;

  logic [ADDR_W-1:0]     act_addr;
  logic                  act_we;
  logic [WORD_W-1:0]     act_wdata;
  logic [WORD_BYTES-1:0] act_be;
  logic [IDX_W-1:0]      act_idx;
  logic [TAG_W-1:0]      act_tag;
  logic [WSEL_W-1:0]     act_wsel;

  logic             line_valid, line_dirty, hit, victim_dirty;
  logic [TAG_W-1:0] line_tag;
  logic [LINE_W-1:0] rd_line, merged, wr_line;
  logic access_en, fill_en, lat_req, ld_wb, ld_fill;
  logic line_we;
  logic unused_bits;

  // outside a miss the live request is looked up; during one the latched copy
  always_comb begin
    if (state == ST_IDLE) begin
      act_addr  = cpu_addr;
      act_we    = cpu_we;
      act_wdata = cpu_wdata;
      act_be    = cpu_be;
    end else begin
      act_addr  = req_addr_q;
      act_we    = req_we_q;
      act_wdata = req_wdata_q;
      act_be    = req_be_q;
    end
  end

  assign act_idx = act_addr[OFF_W+IDX_W-1:OFF_W];
  assign act_tag = act_addr[ADDR_W-1:OFF_W+IDX_W];

  if (LINE_WORDS > 1) begin : g_wsel_multi
    assign act_wsel = act_addr[OFF_W-1:BOFF_W];
  end else begin : g_wsel_single
    assign act_wsel = '0;
  end

  assign unused_bits = ^act_addr[OFF_W-1:0];

  cache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (act_idx),
    .rd_valid (line_valid),
    .rd_dirty (line_dirty),
    .rd_tag   (line_tag),
    .wr_en    (line_we),
    .wr_idx   (act_idx),
    .wr_tag   (act_tag),
    .wr_dirty (!fill_en)
  );

  cache_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
    .clk     (clk),
    .rd_idx  (act_idx),
    .rd_line (rd_line),
    .wr_en   (line_we),
    .wr_idx  (act_idx),
    .wr_line (wr_line)
  );

  assign hit          = line_valid && (line_tag == act_tag);
  assign victim_dirty = line_valid && line_dirty;

  cache_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cpu_req       (cpu_req),
    .hit           (hit),
    .victim_dirty  (victim_dirty),
    .mem_req_ready (mem_req_ready),
    .mem_rvalid    (mem_rvalid),
    .state         (state),
    .access_en     (access_en),
    .fill_en       (fill_en),
    .lat_req       (lat_req),
    .ld_wb         (ld_wb),
    .ld_fill       (ld_fill),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .cpu_done      (cpu_done)
  );

  always_comb begin
    merged = rd_line;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (act_be[b]) merged[int'(act_wsel)*WORD_W + b*8 +: 8] = act_wdata[b*8 +: 8];
    end
  end

  assign line_we = fill_en || (access_en && act_we);
  assign wr_line = fill_en ? mem_rdata : merged;

  always_ff @(posedge clk) begin
    if (lat_req) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
      req_be_q    <= cpu_be;
    end
    if (ld_wb) begin
      mem_req_addr <= {line_tag, act_idx, {OFF_W{1'b0}}};
      mem_wdata    <= rd_line;
    end else if (ld_fill) begin
      mem_req_addr <= {act_tag, act_idx, {OFF_W{1'b0}}};
    end
    if (access_en && !act_we) cpu_rdata <= rd_line[int'(act_wsel)*WORD_W +: WORD_W];
  end

  assign cpu_stall = (state != ST_IDLE);
endmodule

// File: rtl/dm_wb_cache_chk.sv
`timescale 1ns/1ps
module dm_wb_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cpu_done && !cpu_stall && !mem_req_valid)); // R1

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall && hit) |=> (cpu_done && !mem_req_valid)); // R3

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall && !hit) |=> (cpu_stall && !cpu_done)); // R4

  AST_DONE_UNSTALLED: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_stall); // R4

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && mem_req_we) |=> (mem_req_valid && !mem_req_we)); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr))); // R11
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req       (cpu_req),
  .cpu_stall     (cpu_stall),
  .cpu_done      (cpu_done),
  .hit           (hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/tb_dm_wb_cache.sv
`timescale 1ns/1ps
module tb_line_mem #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int OFF_W = 4,
  parameter int MEM_LINES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] wdata,
  output logic              req_ready,
  output logic              rvalid,
  output logic [LINE_W-1:0] rdata
);
  localparam int WPL = LINE_W / 32;
  logic [LINE_W-1:0] store [MEM_LINES];
  int cnt, rd_count, wr_count, delay, blk;
  logic pend, prev_we, rd_after_wr;
  logic [ADDR_W-1:0] last_wr_addr, last_rd_addr;
  logic [LINE_W-1:0] pend_data;

  function automatic logic [31:0] iw(input int wa);
    return (wa * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  assign blk = int'(req_addr >> OFF_W) % MEM_LINES;
  assign req_ready = req_valid && (cnt == 2);

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (rst) begin
      cnt <= 0; rd_count <= 0; wr_count <= 0; pend <= 1'b0; delay <= 0;
      prev_we <= 1'b0; rd_after_wr <= 1'b0;
      for (int l = 0; l < MEM_LINES; l++)
        for (int w = 0; w < WPL; w++) store[l][w*32 +: 32] <= iw(l*WPL + w);
    end else begin
      if (req_valid && req_ready) begin
        cnt <= 0;
        if (req_we) begin
          store[blk] <= wdata;
          wr_count <= wr_count + 1;
          last_wr_addr <= req_addr;
          prev_we <= 1'b1;
        end else begin
          rd_count <= rd_count + 1;
          last_rd_addr <= req_addr;
          rd_after_wr <= prev_we;
          prev_we <= 1'b0;
          pend <= 1'b1;
          delay <= 3;
          pend_data <= store[blk];
        end
      end else if (req_valid) begin
        cnt <= cnt + 1;
      end
      if (pend) begin
        if (delay > 1) delay <= delay - 1;
        else begin
          rvalid <= 1'b1;
          rdata <= pend_data;
          pend <= 1'b0;
        end
      end
    end
  end
endmodule

module tb_dm_wb_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // default geometry: 64 lines x 16 bytes
  logic c_req = 0, c_we = 0;
  logic [31:0] c_addr = 0, c_wdata = 0;
  logic [3:0] c_be = 0;
  logic [31:0] c_rdata;
  logic c_done, c_stall;
  logic m_v, m_rdy, m_we, m_rv;
  logic [31:0] m_addr;
  logic [127:0] m_wd, m_rd;

  dm_wb_cache dut (
    .clk(clk), .rst(rst), .cpu_req(c_req), .cpu_we(c_we), .cpu_addr(c_addr),
    .cpu_wdata(c_wdata), .cpu_be(c_be), .cpu_rdata(c_rdata), .cpu_done(c_done),
    .cpu_stall(c_stall), .mem_req_valid(m_v), .mem_req_ready(m_rdy),
    .mem_req_we(m_we), .mem_req_addr(m_addr), .mem_wdata(m_wd),
    .mem_rvalid(m_rv), .mem_rdata(m_rd));

  tb_line_mem #(.LINE_W(128), .OFF_W(4)) u_mem (
    .clk(clk), .rst(rst), .req_valid(m_v), .req_we(m_we), .req_addr(m_addr),
    .wdata(m_wd), .req_ready(m_rdy), .rvalid(m_rv), .rdata(m_rd));

  // small geometry: 8 lines x one word
  logic s_req = 0;
  logic [31:0] s_addr = 0;
  logic [31:0] s_rdata;
  logic s_done, s_stall;
  logic sm_v, sm_rdy, sm_we, sm_rv;
  logic [31:0] sm_addr, sm_wd, sm_rd;

  dm_wb_cache #(.LINES(8), .LINE_WORDS(1)) dut8 (
    .clk(clk), .rst(rst), .cpu_req(s_req), .cpu_we(1'b0), .cpu_addr(s_addr),
    .cpu_wdata(32'h0), .cpu_be(4'h0), .cpu_rdata(s_rdata), .cpu_done(s_done),
    .cpu_stall(s_stall), .mem_req_valid(sm_v), .mem_req_ready(sm_rdy),
    .mem_req_we(sm_we), .mem_req_addr(sm_addr), .mem_wdata(sm_wd),
    .mem_rvalid(sm_rv), .mem_rdata(sm_rd));

  tb_line_mem #(.LINE_W(32), .OFF_W(2)) u_mem8 (
    .clk(clk), .rst(rst), .req_valid(sm_v), .req_we(sm_we), .req_addr(sm_addr),
    .wdata(sm_wd), .req_ready(sm_rdy), .rvalid(sm_rv), .rdata(sm_rd));

  logic [31:0] gold [1024];

  function automatic logic [31:0] iw(input int wa);
    return (wa * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic big_acc(input logic [31:0] a, input logic we, input logic [31:0] d,
                         input logic [3:0] be, output int lat, output logic st1,
                         output logic [31:0] rd);
    @(negedge clk);
    c_req = 1'b1; c_we = we; c_addr = a; c_wdata = d; c_be = be;
    @(negedge clk);
    c_req = 1'b0;
    lat = 1;
    st1 = c_stall;
    while (!c_done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    rd = c_rdata;
    if (we)
      for (int b = 0; b < 4; b++)
        if (be[b]) gold[int'(a >> 2)][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic small_acc(input logic [31:0] a, output int lat);
    @(negedge clk);
    s_req = 1'b1; s_addr = a;
    @(negedge clk);
    s_req = 1'b0;
    lat = 1;
    while (!s_done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // R11: a stalled memory request must stay put
  int hold_bad = 0;
  logic pv = 1'b0, pw = 1'b0;
  logic [31:0] pa = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pv && (m_v !== 1'b1 || m_addr !== pa || m_we !== pw)) hold_bad++;
      pv = m_v && !m_rdy;
      pa = m_addr;
      pw = m_we;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat, r0, w0;
    logic st;
    logic [31:0] rd, a, d, e;
    for (int i = 0; i < 1024; i++) gold[i] = iw(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!c_done && !c_stall && !m_v, "R1 reset outputs", {c_done, c_stall, m_v}, 0);

    // cold pass: every line misses
    for (int l = 0; l < 64; l++) begin
      a = l*16 + (l%4)*4;
      r0 = u_mem.rd_count; w0 = u_mem.wr_count;
      big_acc(a, 0, 0, 0, lat, st, rd);
      chk(lat > 1 && st, "R1 R4 cold miss stalls", {lat, st}, 1);
      chk(u_mem.rd_count == r0+1 && u_mem.last_rd_addr == l*16, "R4 line fetch address", u_mem.last_rd_addr, l*16);
      chk(u_mem.wr_count == w0, "R7 no write for invalid victim", u_mem.wr_count, w0);
      chk(rd == gold[a>>2], "R9 cold read data", rd, gold[a>>2]);
    end

    // repeated pass: every line hits
    for (int l = 0; l < 64; l++) begin
      a = l*16 + (l%4)*4;
      r0 = u_mem.rd_count;
      big_acc(a, 0, 0, 0, lat, st, rd);
      chk(lat == 1 && !st && u_mem.rd_count == r0, "R3 hit latency", lat, 1);
      chk(rd == gold[a>>2], "R9 hit read data", rd, gold[a>>2]);
    end

    // stores over the resident region: hits, cache only
    for (int w = 0; w < 256; w++) begin
      r0 = u_mem.rd_count; w0 = u_mem.wr_count;
      d = (w * 32'h0101_0101) ^ 32'h3C3C_A5A5;
      big_acc(w*4, 1, d, 4'((w % 15) + 1), lat, st, rd);
      chk(lat == 1 && u_mem.rd_count == r0, "R3 store hit latency", lat, 1);
      chk(u_mem.wr_count == w0, "R5 store hit no memory write", u_mem.wr_count, w0);
    end
    for (int w = 0; w < 256; w += 5) begin
      big_acc(w*4, 0, 0, 0, lat, st, rd);
      chk(rd == gold[w], "R9 read after store hit", rd, gold[w]);
    end

    // conflicting region: dirty victims go out before the fetch
    for (int l = 0; l < 64; l++) begin
      a = 1024 + l*16 + 8;
      r0 = u_mem.rd_count; w0 = u_mem.wr_count;
      big_acc(a, 0, 0, 0, lat, st, rd);
      chk(u_mem.wr_count == w0+1 && u_mem.last_wr_addr == l*16, "R6 dirty victim address", u_mem.last_wr_addr, l*16);
      chk(u_mem.rd_count == r0+1 && u_mem.last_rd_addr == 1024 + l*16 && u_mem.rd_after_wr,
          "R6 fetch after writeback", u_mem.last_rd_addr, 1024 + l*16);
      chk(rd == gold[a>>2], "R9 conflict read data", rd, gold[a>>2]);
    end

    // original region again: clean victims, data came back from memory
    for (int l = 0; l < 64; l++) begin
      a = l*16 + 12;
      r0 = u_mem.rd_count; w0 = u_mem.wr_count;
      big_acc(a, 0, 0, 0, lat, st, rd);
      chk(u_mem.wr_count == w0 && u_mem.rd_count == r0+1, "R7 clean victim no write", u_mem.wr_count, w0);
      chk(rd == gold[a>>2], "R9 data survives writeback", rd, gold[a>>2]);
    end

    // store misses with partial byte enables
    for (int l = 0; l < 16; l++) begin
      a = 2048 + l*16 + 4;
      r0 = u_mem.rd_count;
      d = 32'hF00D_0000 | l;
      big_acc(a, 1, d, 4'b0101, lat, st, rd);
      chk(lat > 1 && u_mem.rd_count == r0+1 && u_mem.last_rd_addr == 2048 + l*16, "R8 store miss fetches", u_mem.last_rd_addr, 2048 + l*16);
      big_acc(a, 0, 0, 0, lat, st, rd);
      chk(lat == 1 && rd == gold[a>>2], "R8 merged bytes", rd, gold[a>>2]);
      e = iw(int'((a >> 2) - 1));
      big_acc(a - 4, 0, 0, 0, lat, st, rd);
      chk(lat == 1 && rd == e, "R8 rest of line fetched", rd, e);
    end

    // mapping of address 1200: line 11
    big_acc(1200, 1, 32'hCAFE_1200, 4'hF, lat, st, rd);
    w0 = u_mem.wr_count;
    big_acc(3248, 0, 0, 0, lat, st, rd);
    chk(u_mem.wr_count == w0+1 && u_mem.last_wr_addr == 1200, "R2 1200 and 3248 share a line", u_mem.last_wr_addr, 1200);
    big_acc(1184, 0, 0, 0, lat, st, rd);
    big_acc(3248, 0, 0, 0, lat, st, rd);
    chk(lat == 1, "R2 neighbour line leaves line 11 alone", lat, 1);
    w0 = u_mem.wr_count;
    big_acc(1200, 0, 0, 0, lat, st, rd);
    chk(u_mem.wr_count == w0 && rd == 32'hCAFE_1200, "R2 R9 1200 read back", rd, 32'hCAFE_1200);

    // small geometry sequence
    begin
      int seq [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
      bit hexp [8] = '{0, 0, 1, 1, 0, 0, 1, 0};
      for (int i = 0; i < 8; i++) begin
        small_acc(seq[i]*4, lat);
        chk((lat == 1) == hexp[i], "R10 eight-line sequence", lat, hexp[i] ? 1 : 2);
      end
    end

    chk(hold_bad == 0, "R11 request held while not ready", hold_bad, 0);
    finish_run();
  end
endmodule